// File: doc/BRIEF.md
# SDRAM Bank Auto-Precharge Timer

This block follows every bank of a small SDRAM controller through the commands that close a row on their own: a burst write with automatic precharge and a burst read with automatic precharge. Each bank has its own state machine and down-counter. The controller can therefore have one bank streaming data while the other bank is already precharging. The block is given the command, the addressed bank, the programmed burst-length code, the CAS latency and the row precharge time tRP in clocks. It reports the state of each bank and a per-bank flag that says a new activate may be issued. Any command that the current bank state or configuration cannot accept is refused. A refused command raises an error pulse and leaves the bank's state unchanged.

The block only keeps time. Data, addresses, refresh and the memory array are handled elsewhere. The controller reads the per-bank ready flag before it issues an activate.

Top module: `apt_bank_timer`

## Requirements
- R1: After synchronous reset every bank reports idle (state code 0), every activate-ready bit is 1 and the error flag is 0.
- R2: An activate (op 1) to an idle bank moves that bank to active (state code 1) one clock later. While the bank is active its ready bit is 0.
- R3: A write with auto-precharge (op 2) issued in cycle t to an active bank puts the bank in writing (state code 2) from cycle t+1. Precharging (state code 4) begins in cycle t+BL, which is one clock after the last data beat in cycle t+BL-1. When BL is 1, precharging begins in cycle t+1.
- R4: After a write with auto-precharge, the bank returns to idle and its ready bit rises in cycle t+BL+tRP. This is exactly tRP+1 clocks after the last write data beat.
- R5: A read with auto-precharge (op 3) issued in cycle t shows reading (state code 3) from cycle t+1. Its last data leaves in cycle t+CL+BL-1. Precharging starts CL-1 clocks before that last data, and ready rises tRP clocks after precharging starts. This holds for CL of 2 and 3.
- R6: Burst codes 0, 1, 2 and 3 select burst lengths 1, 2, 4 and 8.
- R7: Code 7 (full page) and the reserved codes 4 to 6 refuse both auto-precharge commands. The error pulse is raised, and the bank stays active with ready at 0 because no precharge is scheduled.
- R8: An auto-precharge command to a bank that is not active is refused. This includes an idle bank. The bank's state does not change.
- R9: An activate to a bank that is not idle is refused, and the bank's state does not change.
- R10: An auto-precharge command is refused when the CAS latency input is anything other than 2 or 3.
- R11: The banks are independent. A command to one bank never changes the state or ready bit of another bank.
- R12: The error flag is high for exactly the one cycle after a refused command, and it is low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 2 | 0 no-op, 1 activate, 2 write with auto-precharge, 3 read with auto-precharge |
| cmd_bank | input | BANK_W | Addressed bank |
| burst_code | input | 3 | Burst length code (0..3 give 1,2,4,8; 7 full page) |
| cas_lat | input | 2 | CAS latency in clocks (2 or 3) |
| trp | input | TRP_W | Precharge time in clocks (1..7; 0 treated as 1). Must stay stable while a bank precharges |
| bank_state | output | NUM_BANKS*3 | Per-bank state code, bank b at bits [3b+2:3b] |
| act_ready | output | NUM_BANKS | Per-bank ready-to-activate flag |
| cmd_err | output | 1 | One-cycle pulse after a refused command |

## Verification
The hardest case to produce from the ports is the exact cycle in which ready returns. It depends on burst length, tRP and, for reads, the CAS latency at once. A single hand-written case would not show an off-by-one in any one of these terms. The bench therefore sweeps every bank, both auto-precharge commands, all four legal burst codes, both latencies and every tRP from 1 to 7. For each case it counts edges from the command to the start of precharge and to ready, and compares the counts with BL and BL+tRP. A second hard case is two banks overlapping in different phases. The bench reaches it by staggering a long write on one bank against a shorter read on the other, then checking each bank's ready cycle separately.

// File: rtl/apt_pkg.sv
package apt_pkg;

  typedef enum logic [2:0] {
    BK_IDLE   = 3'd0,
    BK_ACTIVE = 3'd1,
    BK_WRITE  = 3'd2,
    BK_READ   = 3'd3,
    BK_PRECH  = 3'd4
  } bank_st_t;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_ACT = 2'd1,
    OP_WRA = 2'd2,
    OP_RDA = 2'd3
  } cmd_op_t;

  // clocks by which a read's internal precharge leads its last output beat
  function automatic int rd_lead(input int cl);
    return cl - 1;
  endfunction

endpackage

// File: rtl/apt_cfg_decode.sv
module apt_cfg_decode
  import apt_pkg::*;
#(
  parameter int MAX_BURST = 8,
  parameter int CNT_W     = 3
) (
  input  cmd_op_t          op,
  input  logic [2:0]       burst_code,
  input  logic [1:0]       cas_lat,
  output logic             cfg_ok,
  output logic             burst_one,
  output logic [CNT_W-1:0] burst_load
);

  localparam int MAX_CODE = $clog2(MAX_BURST);

  logic cl_ok;
  logic bl_ok;
  int   bl;
  int   start_off;

  always_comb begin
    cl_ok = (cas_lat == 2'd2) || (cas_lat == 2'd3);
    bl_ok = (int'(burst_code) <= MAX_CODE);
    cfg_ok = cl_ok && bl_ok;
    bl = bl_ok ? (1 << burst_code) : 1;
    // offset from the command cycle to the first precharging cycle
    if (op == OP_RDA) begin
      start_off = int'(cas_lat) + bl - 1 - rd_lead(int'(cas_lat));
    end else begin
      start_off = bl;
    end
    if (start_off < 1) start_off = 1;
    burst_one  = (start_off == 1);
    burst_load = (start_off >= 2) ? CNT_W'(start_off - 2) : '0;
  end

endmodule

// File: rtl/apt_bank_fsm.sv
module apt_bank_fsm
  import apt_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int TRP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  cmd_op_t          op,
  input  logic             cfg_ok,
  input  logic             burst_one,
  input  logic [CNT_W-1:0] burst_load,
  input  logic [TRP_W-1:0] trp,
  output bank_st_t         st_q,
  output logic             ready_q,
  output logic             illegal
);

  localparam int PRE_MAX = (1 << TRP_W) - 2;

  bank_st_t         st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] trp_m1;
  logic             apc_op;

  assign trp_m1 = (trp == '0) ? '0 : CNT_W'(trp - 1'b1);
  assign apc_op = (op == OP_WRA) || (op == OP_RDA);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    illegal = 1'b0;
    case (st_q)
      BK_IDLE: begin
        if (sel) begin
          if (op == OP_ACT) st_d = BK_ACTIVE;
          else              illegal = 1'b1;
        end
      end
      BK_ACTIVE: begin
        if (sel) begin
          if (apc_op && cfg_ok) begin
            if (burst_one) begin
              st_d  = BK_PRECH;
              cnt_d = trp_m1;
            end else begin
              st_d  = (op == OP_WRA) ? BK_WRITE : BK_READ;
              cnt_d = burst_load;
            end
          end else begin
            illegal = 1'b1;
          end
        end
      end
      BK_WRITE, BK_READ: begin
        if (sel) illegal = 1'b1;
        if (cnt_q == '0) begin
          st_d  = BK_PRECH;
          cnt_d = trp_m1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      BK_PRECH: begin
        if (sel) illegal = 1'b1;
        if (cnt_q == '0) st_d = BK_IDLE;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: begin
        st_d  = BK_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= BK_IDLE;
      cnt_q   <= '0;
      ready_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      ready_q <= (st_d == BK_IDLE);
    end
  end

  // R4
  ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_q) |-> $past(st_q) == BK_PRECH);

  // R3
  write_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == BK_WRITE) |=> (st_q == BK_WRITE || st_q == BK_PRECH));

  // R5
  read_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == BK_READ) |=> (st_q == BK_READ || st_q == BK_PRECH));

  // R8
  refused_hold_chk: assert property (@(posedge clk) disable iff (rst)
    illegal && (st_q == BK_IDLE || st_q == BK_ACTIVE) |=> st_q == $past(st_q));

  // R2
  active_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == BK_ACTIVE) |-> !ready_q);

  // R4
  prech_count_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == BK_PRECH) |-> (int'(cnt_q) <= PRE_MAX));

endmodule

// File: rtl/apt_bank_timer.sv
module apt_bank_timer
  import apt_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int MAX_BURST = 8,
  parameter int TRP_W     = 3,
  parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             cmd_op,
  input  logic [BANK_W-1:0]      cmd_bank,
  input  logic [2:0]             burst_code,
  input  logic [1:0]             cas_lat,
  input  logic [TRP_W-1:0]       trp,
  output logic [NUM_BANKS*3-1:0] bank_state,
  output logic [NUM_BANKS-1:0]   act_ready,
  output logic                   cmd_err
);

  localparam int BL_CW = $clog2(MAX_BURST);
  localparam int CNT_W = (BL_CW > TRP_W) ? BL_CW : TRP_W;

  cmd_op_t          op;
  logic             cfg_ok;
  logic             burst_one;
  logic [CNT_W-1:0] burst_load;
  logic [NUM_BANKS-1:0] illegal_vec;

  assign op = cmd_op_t'(cmd_op);

  apt_cfg_decode #(
    .MAX_BURST (MAX_BURST),
    .CNT_W     (CNT_W)
  ) dec_i (
    .op         (op),
    .burst_code (burst_code),
    .cas_lat    (cas_lat),
    .cfg_ok     (cfg_ok),
    .burst_one  (burst_one),
    .burst_load (burst_load)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_st_t st;
    logic     sel;
    assign sel = (op != OP_NOP) && (int'(cmd_bank) == b);

    apt_bank_fsm #(
      .CNT_W (CNT_W),
      .TRP_W (TRP_W)
    ) fsm_i (
      .clk        (clk),
      .rst        (rst),
      .sel        (sel),
      .op         (op),
      .cfg_ok     (cfg_ok),
      .burst_one  (burst_one),
      .burst_load (burst_load),
      .trp        (trp),
      .st_q       (st),
      .ready_q    (act_ready[b]),
      .illegal    (illegal_vec[b])
    );
    assign bank_state[b*3 +: 3] = st;
  end

  always_ff @(posedge clk) begin
    if (rst) cmd_err <= 1'b0;
    else     cmd_err <= |illegal_vec;
  end

  // R12
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> $past(cmd_op) != 2'd0);

  // R11
  one_bank_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(illegal_vec));

endmodule

// File: tb/apt_bank_timer_tb_top.sv
`timescale 1ns/1ps
module apt_bank_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] cmd_op;
  logic [0:0] cmd_bank;
  logic [2:0] burst_code;
  logic [1:0] cas_lat;
  logic [2:0] trp;
  logic [5:0] bank_state;
  logic [1:0] act_ready;
  logic       cmd_err;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  apt_bank_timer dut_i (
    .clk        (clk),
    .rst        (rst),
    .cmd_op     (cmd_op),
    .cmd_bank   (cmd_bank),
    .burst_code (burst_code),
    .cas_lat    (cas_lat),
    .trp        (trp),
    .bank_state (bank_state),
    .act_ready  (act_ready),
    .cmd_err    (cmd_err)
  );

  function automatic int st_of(input int b);
    return int'(bank_state[b*3 +: 3]);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int op, input int b);
    cmd_op   = 2'(op);
    cmd_bank = 1'(b);
  endtask

  // one full activate + auto-precharge sequence, timed from the command edge
  task automatic run_case(input int b, input int op, input int c, input int cl, input int tr);
    int bl;
    int n_pre;
    int n_rdy;
    int first_st;
    int exp_first;
    bl = 1 << c;
    n_pre = 0;
    n_rdy = 0;
    first_st = -1;
    trp = 3'(tr);
    burst_code = 3'(c);
    cas_lat = 2'(cl);
    @(negedge clk);
    drive(1, b);
    @(negedge clk);
    chk(st_of(b) == 1 && !act_ready[b], "R2 activate", st_of(b), 1);
    drive(op, b);
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (n == 1) begin
        drive(0, b);
        first_st = st_of(b);
      end
      if (st_of(b) == 4 && n_pre == 0) n_pre = n;
      if (act_ready[b]) begin
        n_rdy = n;
        break;
      end
    end
    exp_first = (bl == 1) ? 4 : ((op == 2) ? 2 : 3);
    if (op == 2) begin
      chk(first_st == exp_first, "R3 first state", first_st, exp_first);
      chk(n_pre == bl, "R3 R6 precharge start", n_pre, bl);
      chk(n_rdy == bl + tr, "R4 ready cycle", n_rdy, bl + tr);
    end else begin
      chk(first_st == exp_first, "R5 first state", first_st, exp_first);
      chk(n_pre == (cl + bl - 1) - (cl - 1), "R5 R6 precharge start", n_pre, bl);
      chk(n_rdy == n_pre + tr, "R5 ready cycle", n_rdy, n_pre + tr);
    end
    chk(st_of(b) == 0, "R4 back to idle", st_of(b), 0);
  endtask

  task automatic expect_refused(input int b, input int exp_st, input string req);
    @(negedge clk);
    drive(0, b);
    chk(cmd_err == 1'b1, req, int'(cmd_err), 1);
    chk(st_of(b) == exp_st, req, st_of(b), exp_st);
    @(negedge clk);
    chk(cmd_err == 1'b0, "R12 error pulse ends", int'(cmd_err), 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int r0;
    int r1;
    rst = 1'b1;
    cmd_op = 2'd0;
    cmd_bank = 1'b0;
    burst_code = 3'd2;
    cas_lat = 2'd2;
    trp = 3'd3;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(bank_state == 6'd0, "R1 states", int'(bank_state), 0);
    chk(act_ready == 2'b11, "R1 ready", int'(act_ready), 3);
    chk(cmd_err == 1'b0, "R1 error", int'(cmd_err), 0);

    // sweep over bank, op, burst, latency and tRP
    for (int b = 0; b < 2; b++)
      for (int op = 2; op <= 3; op++)
        for (int c = 0; c < 4; c++)
          for (int cl = 2; cl <= 3; cl++)
            for (int tr = 1; tr <= 7; tr++)
              run_case(b, op, c, cl, tr);

    // R11 overlapping banks
    trp = 3'd7;
    cas_lat = 2'd3;
    @(negedge clk); drive(1, 0);
    @(negedge clk); drive(1, 1);
    @(negedge clk);
    burst_code = 3'd3;
    drive(2, 0);
    r0 = 0;
    r1 = 0;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (n == 1) begin
        burst_code = 3'd2;
        drive(3, 1);
      end
      if (n == 2) drive(0, 0);
      if (n == 1) chk(st_of(1) == 1, "R11 other bank untouched", st_of(1), 1);
      if (act_ready[0] && r0 == 0) r0 = n;
      if (act_ready[1] && r1 == 0) r1 = n;
      if (r0 != 0 && r1 != 0) break;
    end
    chk(r0 == 15, "R11 bank0 ready", r0, 15);
    chk(r1 == 12, "R11 bank1 ready", r1, 12);

    // R8 write to idle bank
    burst_code = 3'd2;
    cas_lat = 2'd2;
    trp = 3'd2;
    @(negedge clk); drive(2, 0);
    expect_refused(0, 0, "R8 write to idle");
    drive(3, 1);
    expect_refused(1, 0, "R8 read to idle");

    // R9 double activate
    drive(1, 0);
    @(negedge clk); drive(1, 0);
    expect_refused(0, 1, "R9 activate active bank");

    // R7 full page and reserved codes
    burst_code = 3'd7;
    drive(2, 0);
    expect_refused(0, 1, "R7 full page write");
    repeat (10) @(negedge clk);
    chk(st_of(0) == 1 && !act_ready[0], "R7 no precharge scheduled", st_of(0), 1);
    burst_code = 3'd5;
    drive(3, 0);
    expect_refused(0, 1, "R7 reserved code read");

    // R10 bad latency
    burst_code = 3'd2;
    cas_lat = 2'd1;
    drive(2, 0);
    expect_refused(0, 1, "R10 latency 1");
    cas_lat = 2'd2;

    // R9 activate while writing; R8 second write while writing
    drive(2, 0);
    @(negedge clk);
    drive(1, 0);
    expect_refused(0, 2, "R9 activate during write");
    drive(2, 0);
    expect_refused(0, 4, "R8 write during precharge");
    repeat (6) @(negedge clk);
    chk(st_of(0) == 0 && act_ready[0], "R4 idle after refusals", st_of(0), 0);
    chk(cmd_err == 1'b0, "R12 quiet", int'(cmd_err), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule